// File: doc/BRIEF.md
# RGB Panel Sync Timing Generator

This block produces the horizontal sync, vertical sync and data-enable waveforms for a parallel RGB LCD panel that is clocked by a dot clock. It runs entirely in the pixel clock domain. A downstream pixel source receives a request strobe together with the current column and row inside the active area. It also receives a one-cycle pulse when the last visible pixel of a frame goes out.

Every timing value arrives on plain configuration inputs. These values are the line and frame lengths, the sync pulse widths, the wait from the leading edge of sync to the first active pixel or line, and the size of the active area. Further inputs set the polarity of each output, the dot-clock edge choice, a data-enable presence switch and a master sync switch. The block copies all configuration into a shadow bank only at a frame boundary. Writes made during a frame therefore cannot tear the picture. A run input starts scanning. When run is dropped, the frame in progress completes and the block then reports idle.

Top module: `rgb_sync_gen`

## Requirements
- R1: Within each line of `cfg_h_total` clocks, HSYNC is at its active level for the first `cfg_h_sync_w` clocks and at the inactive level otherwise. The active level is high when `cfg_hs_act_high`=1 and low when it is 0.
- R2: With `cfg_v_total_in_clk`=0 and `cfg_v_sync_in_clk`=0, a frame lasts `cfg_v_total` lines. VSYNC is active, with polarity set by `cfg_vs_act_high`, during the first `cfg_v_sync_w` lines.
- R3: With `cfg_v_sync_in_clk`=1, VSYNC is active for the first `cfg_v_sync_w` pixel clocks of the frame. With `cfg_v_total_in_clk`=1, the frame lasts `cfg_v_total` pixel clocks, and lines still wrap every `cfg_h_total` clocks inside it.
- R4: A pixel is active when its column h satisfies `cfg_h_wait` <= h < `cfg_h_wait`+`cfg_h_valid` and its row v satisfies `cfg_v_wait` <= v < `cfg_v_wait`+`cfg_v_lines`. Both counts start at the leading edge of sync. `pix_req` is high exactly on active pixels. DE follows the same window at the polarity set by `cfg_de_act_high` when `cfg_de_enable`=1, and stays inactive when `cfg_de_enable`=0.
- R5: While `pix_req` is high, `pos_x` equals h-`cfg_h_wait` and `pos_y` equals v-`cfg_v_wait`. Both are zero otherwise.
- R6: `frame_done` pulses for one clock per frame, together with the last active pixel of the last active line.
- R7: With `cfg_sync_enable`=0, HSYNC, VSYNC and DE hold their inactive levels, and `pix_req` and `frame_done` stay low. Frame timing continues to run.
- R8: Configuration is sampled only on the clock that starts a frame. A change made during a frame takes effect from the next frame.
- R9: When `run_en` is low at the end of a frame, scanning stops. `idle` rises together with the outputs of the frame's final clock, and all outputs then hold inactive. Scanning resumes only after `run_en` is seen high while idle.
- R10: After reset, `idle`=1, `pix_req`=0, `frame_done`=0, HSYNC, VSYNC and DE are high (inactive for the active-low defaults), and `dclk_fall`=1.
- R11: `dclk_fall` reports the shadowed dot-clock edge choice (1 = data driven on the falling edge) for the frame being scanned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Scanning enable; sampled at frame boundaries |
| cfg_h_total | input | 12 | Clocks per line |
| cfg_h_sync_w | input | 12 | HSYNC width in clocks |
| cfg_h_wait | input | 12 | Clocks from HSYNC leading edge to first active pixel |
| cfg_h_valid | input | 12 | Active pixels per line |
| cfg_v_total | input | 20 | Frame length in lines or clocks |
| cfg_v_sync_w | input | 20 | VSYNC width in lines or clocks |
| cfg_v_wait | input | 12 | Lines from VSYNC leading edge to first active line |
| cfg_v_lines | input | 12 | Active lines per frame |
| cfg_v_total_in_clk | input | 1 | Frame length counted in clocks |
| cfg_v_sync_in_clk | input | 1 | VSYNC width counted in clocks |
| cfg_hs_act_high | input | 1 | HSYNC polarity |
| cfg_vs_act_high | input | 1 | VSYNC polarity |
| cfg_de_act_high | input | 1 | DE polarity |
| cfg_drive_on_fall | input | 1 | Dot-clock edge choice |
| cfg_de_enable | input | 1 | DE toggles when 1 |
| cfg_sync_enable | input | 1 | Master switch for all outputs |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| dclk_fall | output | 1 | Shadowed edge choice |
| pix_req | output | 1 | Pixel request strobe |
| pos_x | output | 12 | Active column |
| pos_y | output | 12 | Active row |
| frame_done | output | 1 | Last active pixel of frame |
| idle | output | 1 | Not scanning |

## Verification
The rising edge that sees `run_en` high while idle loads the shadow bank and clears the counters. The outputs for frame clock k are then registered on the (k+1)-th rising edge after it, because there is one counter stage and one output register. The bench sits on the loading edge and, for each frame clock, waits one edge and samples just after it. It compares each sample against a model that works from k alone. Frames run back to back, so the first clock of a new frame appears on the edge after the last clock of the previous one. `idle` is due on the same edge as the final clock's outputs, and the fully inactive outputs on the edge after that.

// File: rtl/rgbt_pkg.sv
package rgbt_pkg;
  parameter int unsigned HW = 12;
  parameter int unsigned VW = 12;
  parameter int unsigned FW = 20;

  typedef struct packed {
    logic [HW-1:0] h_period;
    logic [FW-1:0] v_period;
    logic          vper_pix;
  } tim_t;

  typedef struct packed {
    logic [HW-1:0] h_sync;
    logic [HW-1:0] h_wait;
    logic [HW-1:0] h_valid;
    logic [FW-1:0] v_sync;
    logic [VW-1:0] v_wait;
    logic [VW-1:0] v_lines;
    logic          vsw_pix;
    logic          hs_pol;
    logic          vs_pol;
    logic          de_pol;
    logic          dclk_fall;
    logic          de_present;
    logic          sync_on;
  } shape_t;

  typedef struct packed {
    tim_t   tim;
    shape_t shp;
  } tcfg_t;

  localparam tim_t TIM_RESET = '{h_period: HW'(533), v_period: FW'(288), vper_pix: 1'b0};
  localparam shape_t SHP_RESET = '{
    h_sync: HW'(41), h_wait: HW'(49), h_valid: HW'(480),
    v_sync: FW'(10), v_wait: VW'(12), v_lines: VW'(272),
    vsw_pix: 1'b0, hs_pol: 1'b0, vs_pol: 1'b0, de_pol: 1'b0,
    dclk_fall: 1'b1, de_present: 1'b1, sync_on: 1'b1};
  localparam tcfg_t CFG_RESET = '{tim: TIM_RESET, shp: SHP_RESET};
endpackage

// File: rtl/rgbt_ctrl.sv
module rgbt_ctrl
  import rgbt_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  run_en,
  input  logic  frame_end,
  input  tcfg_t cfg_in,
  output logic  running,
  output tcfg_t cfg_q
);
  // shadow bank: loaded only when a frame is about to begin
  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cfg_q   <= CFG_RESET;
    end else if (!running) begin
      if (run_en) begin
        running <= 1'b1;
        cfg_q   <= cfg_in;
      end
    end else if (frame_end) begin
      if (run_en) cfg_q <= cfg_in;
      else        running <= 1'b0;
    end
  end
endmodule

// File: rtl/rgbt_count.sv
module rgbt_count
  import rgbt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          running,
  input  tim_t          tim,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic [FW-1:0] fcnt,
  output logic          frame_end
);
  logic line_end;
  logic last_line;
  logic last_clk;

  assign line_end  = (hcnt == tim.h_period - 1'b1);
  assign last_line = line_end && (FW'(vcnt) == tim.v_period - 1'b1);
  assign last_clk  = (fcnt == tim.v_period - 1'b1);
  assign frame_end = running && (tim.vper_pix ? last_clk : last_line);

  always_ff @(posedge clk) begin
    if (rst || !running || frame_end) begin
      hcnt <= '0;
      vcnt <= '0;
      fcnt <= '0;
    end else begin
      fcnt <= fcnt + 1'b1;
      if (line_end) begin
        hcnt <= '0;
        vcnt <= vcnt + 1'b1;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rgbt_decode.sv
module rgbt_decode
  import rgbt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          running,
  input  shape_t        shp,
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  input  logic [FW-1:0] fcnt,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          dclk_fall,
  output logic          pix_req,
  output logic [HW-1:0] pos_x,
  output logic [VW-1:0] pos_y,
  output logic          frame_done
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] RST_POL = {SHP_RESET.de_pol, SHP_RESET.vs_pol, SHP_RESET.hs_pol};

  logic [HW:0]     h_end;
  logic [VW:0]     v_end;
  logic            h_in, v_in, live, win, last, hs_a, vs_a;
  logic [NSIG-1:0] act, pol, lvl_q;

  assign h_end = {1'b0, shp.h_wait} + {1'b0, shp.h_valid};
  assign v_end = {1'b0, shp.v_wait} + {1'b0, shp.v_lines};
  assign h_in  = (hcnt >= shp.h_wait) && ({1'b0, hcnt} < h_end);
  assign v_in  = (vcnt >= shp.v_wait) && ({1'b0, vcnt} < v_end);
  assign live  = running && shp.sync_on;
  assign win   = live && h_in && v_in;
  assign last  = ({1'b0, hcnt} == h_end - 1'b1) && ({1'b0, vcnt} == v_end - 1'b1);
  assign hs_a  = hcnt < shp.h_sync;
  assign vs_a  = shp.vsw_pix ? (fcnt < shp.v_sync) : (FW'(vcnt) < shp.v_sync);

  assign act = {win && shp.de_present, live && vs_a, live && hs_a};
  assign pol = {shp.de_pol, shp.vs_pol, shp.hs_pol};

  for (genvar i = 0; i < NSIG; i++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (rst) lvl_q[i] <= ~RST_POL[i];
      else     lvl_q[i] <= act[i] ? pol[i] : ~pol[i];
    end
  end

  assign hsync = lvl_q[0];
  assign vsync = lvl_q[1];
  assign de    = lvl_q[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_req    <= 1'b0;
      frame_done <= 1'b0;
      pos_x      <= '0;
      pos_y      <= '0;
      dclk_fall  <= SHP_RESET.dclk_fall;
    end else begin
      pix_req    <= win;
      frame_done <= win && last;
      pos_x      <= win ? hcnt - shp.h_wait : '0;
      pos_y      <= win ? vcnt - shp.v_wait : '0;
      dclk_fall  <= shp.dclk_fall;
    end
  end
endmodule

// File: rtl/rgb_sync_gen.sv
module rgb_sync_gen
  import rgbt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic [HW-1:0] cfg_h_total,
  input  logic [HW-1:0] cfg_h_sync_w,
  input  logic [HW-1:0] cfg_h_wait,
  input  logic [HW-1:0] cfg_h_valid,
  input  logic [FW-1:0] cfg_v_total,
  input  logic [FW-1:0] cfg_v_sync_w,
  input  logic [VW-1:0] cfg_v_wait,
  input  logic [VW-1:0] cfg_v_lines,
  input  logic          cfg_v_total_in_clk,
  input  logic          cfg_v_sync_in_clk,
  input  logic          cfg_hs_act_high,
  input  logic          cfg_vs_act_high,
  input  logic          cfg_de_act_high,
  input  logic          cfg_drive_on_fall,
  input  logic          cfg_de_enable,
  input  logic          cfg_sync_enable,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          dclk_fall,
  output logic          pix_req,
  output logic [HW-1:0] pos_x,
  output logic [VW-1:0] pos_y,
  output logic          frame_done,
  output logic          idle
);
  tcfg_t         cfg_in;
  tcfg_t         cfg_q;
  logic          running;
  logic          frame_end;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [FW-1:0] fcnt;

  always_comb begin
    cfg_in.tim.h_period   = cfg_h_total;
    cfg_in.tim.v_period   = cfg_v_total;
    cfg_in.tim.vper_pix   = cfg_v_total_in_clk;
    cfg_in.shp.h_sync     = cfg_h_sync_w;
    cfg_in.shp.h_wait     = cfg_h_wait;
    cfg_in.shp.h_valid    = cfg_h_valid;
    cfg_in.shp.v_sync     = cfg_v_sync_w;
    cfg_in.shp.v_wait     = cfg_v_wait;
    cfg_in.shp.v_lines    = cfg_v_lines;
    cfg_in.shp.vsw_pix    = cfg_v_sync_in_clk;
    cfg_in.shp.hs_pol     = cfg_hs_act_high;
    cfg_in.shp.vs_pol     = cfg_vs_act_high;
    cfg_in.shp.de_pol     = cfg_de_act_high;
    cfg_in.shp.dclk_fall  = cfg_drive_on_fall;
    cfg_in.shp.de_present = cfg_de_enable;
    cfg_in.shp.sync_on    = cfg_sync_enable;
  end

  rgbt_ctrl u_ctrl (
    .clk(clk), .rst(rst), .run_en(run_en), .frame_end(frame_end),
    .cfg_in(cfg_in), .running(running), .cfg_q(cfg_q)
  );

  rgbt_count u_count (
    .clk(clk), .rst(rst), .running(running), .tim(cfg_q.tim),
    .hcnt(hcnt), .vcnt(vcnt), .fcnt(fcnt), .frame_end(frame_end)
  );

  rgbt_decode u_decode (
    .clk(clk), .rst(rst), .running(running), .shp(cfg_q.shp),
    .hcnt(hcnt), .vcnt(vcnt), .fcnt(fcnt),
    .hsync(hsync), .vsync(vsync), .de(de), .dclk_fall(dclk_fall),
    .pix_req(pix_req), .pos_x(pos_x), .pos_y(pos_y), .frame_done(frame_done)
  );

  assign idle = ~running;
endmodule

// File: rtl/rgb_sync_gen_chk.sv
module rgb_sync_gen_chk
  import rgbt_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          run_en,
  input logic          pix_req,
  input logic          frame_done,
  input logic          idle,
  input logic [HW-1:0] pos_x,
  input logic [VW-1:0] pos_y
);
  p_done_on_pixel_r6: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> pix_req);

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  p_quiet_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (idle && $past(idle)) |-> (!pix_req && !frame_done));

  p_start_needs_run_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(idle) |-> $past(run_en));

  p_x_steps_r5: assert property (@(posedge clk) disable iff (rst)
    (pix_req && $past(pix_req) && (pos_y == $past(pos_y))) |-> (pos_x == $past(pos_x) + 1'b1));
endmodule

bind rgb_sync_gen rgb_sync_gen_chk u_chk (.*);

// File: tb/tb_rgb_sync_gen.sv
module tb_rgb_sync_gen;
  import rgbt_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0;
  logic [HW-1:0] cfg_h_total, cfg_h_sync_w, cfg_h_wait, cfg_h_valid;
  logic [FW-1:0] cfg_v_total, cfg_v_sync_w;
  logic [VW-1:0] cfg_v_wait, cfg_v_lines;
  logic cfg_v_total_in_clk, cfg_v_sync_in_clk, cfg_hs_act_high, cfg_vs_act_high;
  logic cfg_de_act_high, cfg_drive_on_fall, cfg_de_enable, cfg_sync_enable;
  logic hsync, vsync, de, dclk_fall, pix_req, frame_done, idle;
  logic [HW-1:0] pos_x;
  logic [VW-1:0] pos_y;

  int total = 0;
  int bad = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  rgb_sync_gen dut (.*);

  // fields: 0 h_total 1 h_sync 2 h_wait 3 h_valid 4 v_total 5 v_sync 6 v_wait 7 v_lines
  // 8 total_in_clk 9 sync_in_clk 10 hs_pol 11 vs_pol 12 de_pol 13 de_en 14 sync_en
  // 15 expected active pixels 16 falling-edge choice
  localparam int NV = 6;
  localparam int NF = 17;
  localparam int VT [NV][NF] = '{
    '{10, 2, 4, 4,  6,  1, 2, 3, 0, 0, 0, 0, 0, 1, 1, 12, 1},
    '{12, 3, 5, 6,  5,  2, 2, 2, 0, 0, 1, 1, 1, 1, 1, 12, 0},
    '{10, 2, 4, 4,  6, 15, 2, 3, 0, 1, 0, 1, 0, 1, 1, 12, 1},
    '{10, 1, 4, 4, 50,  1, 2, 2, 1, 0, 1, 0, 1, 1, 1,  8, 0},
    '{ 8, 1, 2, 4,  4,  1, 1, 2, 0, 0, 0, 0, 0, 0, 1,  8, 1},
    '{ 8, 1, 2, 4,  4,  1, 1, 2, 0, 0, 1, 1, 1, 1, 0,  0, 1}
  };

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic set_cfg(input int i);
    cfg_h_total        = HW'(VT[i][0]);
    cfg_h_sync_w       = HW'(VT[i][1]);
    cfg_h_wait         = HW'(VT[i][2]);
    cfg_h_valid        = HW'(VT[i][3]);
    cfg_v_total        = FW'(VT[i][4]);
    cfg_v_sync_w       = FW'(VT[i][5]);
    cfg_v_wait         = VW'(VT[i][6]);
    cfg_v_lines        = VW'(VT[i][7]);
    cfg_v_total_in_clk = VT[i][8][0];
    cfg_v_sync_in_clk  = VT[i][9][0];
    cfg_hs_act_high    = VT[i][10][0];
    cfg_vs_act_high    = VT[i][11][0];
    cfg_de_act_high    = VT[i][12][0];
    cfg_de_enable      = VT[i][13][0];
    cfg_sync_enable    = VT[i][14][0];
    cfg_drive_on_fall  = VT[i][16][0];
  endtask

  // Samples one whole frame scanned with vector i; the caller stands on the
  // edge before the frame's first clock outputs are registered.
  task automatic run_frame(input int i, input bit stop, input int chg, input string tag);
    int hp = VT[i][0], hs = VT[i][1], hw = VT[i][2], hv = VT[i][3];
    int vp = VT[i][4], vs = VT[i][5], vw = VT[i][6], vl = VT[i][7];
    bit son = VT[i][14][0];
    int n = VT[i][8] ? vp : hp * vp;
    int m_hs = 0, m_vs = 0, m_de = 0, m_req = 0, m_pos = 0, m_done = 0, m_idle = 0;
    int npix = 0, ndone = 0;
    string vreq = (VT[i][8] != 0 || VT[i][9] != 0) ? "R3" : "R2";
    for (int k = 0; k < n; k++) begin
      int h, v;
      bit win, e_hs, e_vs, e_de, e_done, e_idle;
      @(posedge clk); #1;
      h = k % hp;
      v = k / hp;
      win = son && h >= hw && h < hw + hv && v >= vw && v < vw + vl;
      e_hs = (son && h < hs) ? VT[i][10][0] : !VT[i][10][0];
      e_vs = (son && (VT[i][9] != 0 ? k < vs : v < vs)) ? VT[i][11][0] : !VT[i][11][0];
      e_de = (win && VT[i][13] != 0) ? VT[i][12][0] : !VT[i][12][0];
      e_done = win && h == hw + hv - 1 && v == vw + vl - 1;
      e_idle = stop && k == n - 1;
      if (hsync !== e_hs) m_hs++;
      if (vsync !== e_vs) m_vs++;
      if (de !== e_de) m_de++;
      if (pix_req !== win) m_req++;
      if (win && (int'(pos_x) != h - hw || int'(pos_y) != v - vw)) m_pos++;
      if (!win && (pos_x != 0 || pos_y != 0)) m_pos++;
      if (frame_done !== e_done) m_done++;
      if (idle !== e_idle) m_idle++;
      if (pix_req === 1'b1) npix++;
      if (frame_done === 1'b1) ndone++;
      if (k == 0) chk(dclk_fall === VT[i][16][0], "R11", {tag, " edge select"}, dclk_fall, VT[i][16]);
      if (k == 0 && stop) run_en = 1'b0;
      if (k == n / 2 && chg >= 0) set_cfg(chg);
    end
    chk(m_hs == 0, "R1", {tag, " hsync mismatches"}, m_hs, 0);
    chk(m_vs == 0, vreq, {tag, " vsync mismatches"}, m_vs, 0);
    chk(m_de == 0, "R4", {tag, " de mismatches"}, m_de, 0);
    chk(m_req == 0, "R4", {tag, " pix_req mismatches"}, m_req, 0);
    chk(npix == VT[i][15], son ? "R4" : "R7", {tag, " active pixel count"}, npix, VT[i][15]);
    chk(m_pos == 0, "R5", {tag, " position mismatches"}, m_pos, 0);
    chk(m_done == 0 && ndone == (VT[i][15] > 0 ? 1 : 0), son ? "R6" : "R7",
        {tag, " frame_done pulses"}, ndone, VT[i][15] > 0 ? 1 : 0);
    chk(m_idle == 0, "R9", {tag, " idle timing mismatches"}, m_idle, 0);
  endtask

  task automatic start_run();
    @(negedge clk);
    run_en = 1'b1;
    @(posedge clk);
  endtask

  task automatic check_stopped(input int i, input string tag);
    bit ok;
    @(posedge clk); #1;
    ok = idle === 1'b1 && pix_req === 1'b0 && frame_done === 1'b0 &&
         hsync === !VT[i][10][0] && vsync === !VT[i][11][0] && de === !VT[i][12][0];
    chk(ok, "R9", {tag, " outputs inactive after stop"}, {hsync, vsync, de, pix_req, idle}, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    set_cfg(0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    // R10 reset state
    chk(idle === 1'b1 && pix_req === 1'b0 && frame_done === 1'b0, "R10", "reset status",
        {idle, pix_req, frame_done}, 3'b100);
    chk(hsync === 1'b1 && vsync === 1'b1 && de === 1'b1, "R10", "reset sync levels",
        {hsync, vsync, de}, 3'b111);
    chk(dclk_fall === 1'b1, "R10", "reset edge select", dclk_fall, 1);
    repeat (3) @(posedge clk); #1;
    chk(idle === 1'b1 && pix_req === 1'b0, "R9", "no scan without run_en", {idle, pix_req}, 2'b10);

    // vector table: one frame each, stopped, with a mid-frame write that must not land (R8)
    for (int i = 0; i < NV; i++) begin
      set_cfg(i);
      start_run();
      run_frame(i, 1'b1, (i + 1) % NV, $sformatf("vec%0d", i));
      check_stopped(i, $sformatf("vec%0d", i));
    end

    // R8: continuous run, change mid-frame, new values only from next frame
    set_cfg(0);
    start_run();
    run_frame(0, 1'b0, 1, "R8 frame A");
    run_frame(1, 1'b1, -1, "R8 frame B");
    check_stopped(1, "R8 frame B");

    // restart after stop with pixel-unit frame (R3, R9)
    set_cfg(3);
    start_run();
    run_frame(3, 1'b1, -1, "restart");
    check_stopped(3, "restart");

    finish_up();
  end
endmodule